// File: doc/BRIEF.md
# Waveform Sequencer Control-Flow Unit

This unit walks a program held in an instruction memory and decides, cycle by cycle, which address to fetch next. It handles jumps, counted repetition of a section, and subroutine calls with returns. Every one of those control-flow instructions can be gated by a small external condition input, either by comparing it with a constant in the instruction or by using it as an offset that picks one of several branch targets. Nested calls keep their return point and the state of their repetition counter on a bounded return stack.

Waveform and marker instructions are not executed here. They are presented unchanged on a dispatch port with a valid/ready handshake, and fetching waits while the execution side is not ready. A synchronisation opcode holds the program until the execution engines report idle. Running out of stack in either direction stops the unit with a sticky error. After reset it starts at address 0 and runs until it meets a halt or an error. Only a new reset starts it again.

Top module: `seqflow_core`

## Requirements
- R1: While reset is asserted and directly after it, `halted_o` and `error_o` are 0, `disp_valid_o` is 0 and `mem_addr_o` is 0. Execution begins at address 0. A read issued with `mem_rd_o` at address A returns its word on `mem_rdata_i` in the next cycle.
- R2: The instruction word has these fields. Opcode is in bits 31:28, with WAVE=0, MARKER=1, GOTO=2, CALL=3, RETURN=4, LOOP=5, SYNC=6 and HALT=7. Opcodes 8 to 15 behave as HALT and raise no error. Bit 27 is the write flag, which is carried through untouched. Bits 26:25 are the condition mode: 0 always, 1 equal, 2 multiway, 3 never. Bits 24:23 hold the compare value, bits 22:16 the loop count, and bits 7:0 the target or base address.
- R3: WAVE and MARKER words appear unchanged on `disp_data_o` with `disp_valid_o` high. No other opcode is ever presented on the dispatch port.
- R4: While `disp_valid_o` is high and `disp_ready_i` is low, the valid, the data and `mem_addr_o` all hold their values.
- R5: A GOTO whose condition holds continues at its target. When the condition does not hold, the GOTO continues at the next address.
- R6: In multiway mode the condition always holds and the target is the base address plus `cond_i`, wrapping within the address space.
- R7: In equal mode the condition holds only when `cond_i` equals bits 24:23. In never mode it does not hold.
- R8: A CALL whose condition holds pushes the next address and the current loop state, then jumps to its target. A RETURN whose condition holds pops that frame and resumes there. Calls nest up to 8 deep. A call or return whose condition fails just moves to the next address.
- R9: A CALL that would push a ninth frame, or a RETURN on an empty stack, sets `error_o` and halts. This happens only when the instruction's condition holds. `error_o` stays set until reset.
- R10: LOOP takes a count N from bits 22:16 and runs the section from its target up to the LOOP itself N+1 times in total. Each call level has its own count, saved across a call and restored on return. If the condition fails, the LOOP falls through and ends the current repetition.
- R11: SYNC waits with no dispatch until `idle_i` is high, then moves to the next address.
- R12: HALT sets `halted_o`, which stays high until reset. While halted, `mem_rd_o` and `disp_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_rd_o | output | 1 | Instruction memory read enable |
| mem_addr_o | output | 8 | Instruction memory address (program counter) |
| mem_rdata_i | input | 32 | Instruction word, one cycle after the read |
| cond_i | input | 2 | External condition / branch selector |
| idle_i | input | 1 | Execution engines have drained their queues |
| disp_valid_o | output | 1 | Waveform/marker word is presented |
| disp_ready_i | input | 1 | Execution side accepts the word |
| disp_data_o | output | 32 | Forwarded waveform/marker word |
| halted_o | output | 1 | Unit has stopped |
| error_o | output | 1 | Stack overflow or underflow occurred |

## Verification
The condition test and the stack-bound check meet in one cycle when a conditional CALL executes with the stack already full. A program nests eight calls and then issues an equal-mode CALL whose compare value does not match `cond_i`. The run must go on to dispatch the next wave with no error, while a matching or unconditional CALL at the same depth must halt with the error set. Random programs mix conditional calls, returns, loops and multiway jumps under random ready and idle backpressure. The dispatched word stream and the final halt and error state are compared with an interpreter in the bench.

// File: rtl/seqflow_pkg.sv
package seqflow_pkg;
  typedef enum logic [3:0] {
    OP_WAVE = 4'd0,
    OP_MARK = 4'd1,
    OP_GOTO = 4'd2,
    OP_CALL = 4'd3,
    OP_RET  = 4'd4,
    OP_LOOP = 4'd5,
    OP_SYNC = 4'd6,
    OP_HALT = 4'd7
  } op_e;

  typedef enum logic [1:0] {
    CM_ALWAYS = 2'd0,
    CM_EQ     = 2'd1,
    CM_MULTI  = 2'd2,
    CM_NEVER  = 2'd3
  } cmode_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_HALT  = 2'd2
  } st_e;

  localparam int INSN_W   = 32;
  localparam int OP_LSB   = 28;
  localparam int MODE_LSB = 25;
  localparam int CMP_MSB  = 24;
  localparam int CNT_LSB  = 16;
endpackage

// File: rtl/seqflow_cond.sv
module seqflow_cond
  import seqflow_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int COND_W = 2
) (
  input  logic [1:0]        mode_i,
  input  logic [COND_W-1:0] cmp_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] tgt_o
);
  always_comb begin
    case (mode_i)
      CM_ALWAYS: taken_o = 1'b1;
      CM_EQ:     taken_o = (cond_i == cmp_i);
      CM_MULTI:  taken_o = 1'b1;
      default:   taken_o = 1'b0;
    endcase
    tgt_o = (mode_i == CM_MULTI) ? base_i + ADDR_W'(cond_i) : base_i;
  end
endmodule

// File: rtl/seqflow_stack.sv
module seqflow_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [SP_W-1:0]  sp_q;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign full_o  = (sp_q == SP_W'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign wr_idx  = IDX_W'(sp_q);
  assign rd_idx  = IDX_W'(sp_q - SP_W'(1));
  assign top_o   = mem_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && !full_o) begin
      mem_q[wr_idx] <= push_data_i;
      sp_q          <= sp_q + SP_W'(1);
    end else if (pop_i && !empty_o) begin
      sp_q <= sp_q - SP_W'(1);
    end
  end
endmodule

// File: rtl/seqflow_loopctr.sv
module seqflow_loopctr #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exec_i,
  input  logic             ok_i,
  input  logic [CNT_W-1:0] imm_i,
  input  logic             clear_i,
  input  logic             restore_i,
  input  logic             rest_armed_i,
  input  logic [CNT_W-1:0] rest_cnt_i,
  output logic             jump_o,
  output logic             armed_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    jump_o  = 1'b0;
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (clear_i) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (restore_i) begin
      armed_d = rest_armed_i;
      cnt_d   = rest_cnt_i;
    end else if (exec_i) begin
      if (!ok_i) begin
        armed_d = 1'b0;
      end else if (!armed_q) begin
        if (imm_i != '0) begin
          jump_o  = 1'b1;
          armed_d = 1'b1;
          cnt_d   = imm_i - CNT_W'(1);
        end
      end else if (cnt_q != '0) begin
        jump_o = 1'b1;
        cnt_d  = cnt_q - CNT_W'(1);
      end else begin
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign armed_o = armed_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/seqflow_core.sv
module seqflow_core
  import seqflow_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int COND_W = 2,
  parameter int CNT_W  = 7,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [INSN_W-1:0] mem_rdata_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              idle_i,
  output logic              disp_valid_o,
  input  logic              disp_ready_i,
  output logic [INSN_W-1:0] disp_data_o,
  output logic              halted_o,
  output logic              error_o
);
  localparam int FRAME_W = ADDR_W + 1 + CNT_W;

  st_e               st_q, st_d;
  logic [ADDR_W-1:0] pc_q, pc_d, pc_inc;
  logic              err_q, err_d;

  logic [3:0]        op;
  logic [1:0]        mode;
  logic [COND_W-1:0] cmp;
  logic [CNT_W-1:0]  imm;
  logic [ADDR_W-1:0] base, tgt;
  logic              taken, exec;

  logic               push, pop, full, empty;
  logic [FRAME_W-1:0] push_frame, top_frame;
  logic               loop_exec, lp_jump, lp_armed;
  logic [CNT_W-1:0]   lp_cnt;
  logic               valid;

  assign op     = mem_rdata_i[INSN_W-1:OP_LSB];
  assign mode   = mem_rdata_i[MODE_LSB+1:MODE_LSB];
  assign cmp    = mem_rdata_i[CMP_MSB -: COND_W];
  assign imm    = mem_rdata_i[CNT_LSB +: CNT_W];
  assign base   = mem_rdata_i[ADDR_W-1:0];
  assign exec   = (st_q == ST_EXEC);
  assign pc_inc = pc_q + ADDR_W'(1);

  seqflow_cond #(.ADDR_W(ADDR_W), .COND_W(COND_W)) u_cond (
    .mode_i (mode),
    .cmp_i  (cmp),
    .cond_i (cond_i),
    .base_i (base),
    .taken_o(taken),
    .tgt_o  (tgt)
  );

  assign push_frame = {pc_inc, lp_armed, lp_cnt};

  seqflow_stack #(.DEPTH(DEPTH), .W(FRAME_W)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (pop),
    .push_data_i(push_frame),
    .top_o      (top_frame),
    .full_o     (full),
    .empty_o    (empty)
  );

  seqflow_loopctr #(.CNT_W(CNT_W)) u_loop (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exec_i      (loop_exec),
    .ok_i        (taken),
    .imm_i       (imm),
    .clear_i     (push),
    .restore_i   (pop),
    .rest_armed_i(top_frame[CNT_W]),
    .rest_cnt_i  (top_frame[CNT_W-1:0]),
    .jump_o      (lp_jump),
    .armed_o     (lp_armed),
    .cnt_o       (lp_cnt)
  );

  always_comb begin
    st_d      = st_q;
    pc_d      = pc_q;
    err_d     = err_q;
    push      = 1'b0;
    pop       = 1'b0;
    valid     = 1'b0;
    loop_exec = 1'b0;
    case (st_q)
      ST_FETCH: st_d = ST_EXEC;
      ST_EXEC: begin
        case (op)
          OP_WAVE, OP_MARK: begin
            valid = 1'b1;
            if (disp_ready_i) begin
              pc_d = pc_inc;
              st_d = ST_FETCH;
            end
          end
          OP_GOTO: begin
            pc_d = taken ? tgt : pc_inc;
            st_d = ST_FETCH;
          end
          OP_CALL: begin
            if (taken && full) begin
              err_d = 1'b1;
              st_d  = ST_HALT;
            end else begin
              push = taken;
              pc_d = taken ? tgt : pc_inc;
              st_d = ST_FETCH;
            end
          end
          OP_RET: begin
            if (taken && empty) begin
              err_d = 1'b1;
              st_d  = ST_HALT;
            end else begin
              pop  = taken;
              pc_d = taken ? top_frame[FRAME_W-1 -: ADDR_W] : pc_inc;
              st_d = ST_FETCH;
            end
          end
          OP_LOOP: begin
            loop_exec = 1'b1;
            pc_d      = lp_jump ? tgt : pc_inc;
            st_d      = ST_FETCH;
          end
          OP_SYNC: begin
            if (idle_i) begin
              pc_d = pc_inc;
              st_d = ST_FETCH;
            end
          end
          default: st_d = ST_HALT;
        endcase
      end
      default: st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FETCH;
      pc_q  <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pc_q  <= pc_d;
      err_q <= err_d;
    end
  end

  assign mem_rd_o     = (st_q != ST_HALT);
  assign mem_addr_o   = pc_q;
  assign disp_valid_o = valid && exec;
  assign disp_data_o  = mem_rdata_i;
  assign halted_o     = (st_q == ST_HALT);
  assign error_o      = err_q;
endmodule

// File: rtl/seqflow_chk.sv
module seqflow_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              disp_valid_o,
  input logic              disp_ready_i,
  input logic [31:0]       disp_data_o,
  input logic              halted_o,
  input logic              error_o
);
  AST_DISP_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> (disp_data_o[31:28] == 4'd0 || disp_data_o[31:28] == 4'd1)); // R3

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o && !disp_ready_i |=> disp_valid_o && $stable(disp_data_o) && $stable(mem_addr_o)); // R4

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o); // R9

  AST_ERR_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> halted_o); // R9

  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o); // R12

  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_rd_o && !disp_valid_o); // R12
endmodule

bind seqflow_core seqflow_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_rd_o    (mem_rd_o),
  .mem_addr_o  (mem_addr_o),
  .disp_valid_o(disp_valid_o),
  .disp_ready_i(disp_ready_i),
  .disp_data_o (disp_data_o),
  .halted_o    (halted_o),
  .error_o     (error_o)
);

// File: tb/sim_seqflow_core.sv
`timescale 1ns/1ps
module sim_seqflow_core;
  localparam int AW = 8;
  localparam int NMEM = 256;
  localparam int MAXREC = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd;
  logic [7:0]  mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [1:0]  cond = '0;
  logic        idle = 1'b1;
  logic        disp_valid;
  logic        disp_ready = 1'b1;
  logic [31:0] disp_data;
  logic        halted, error;

  logic [31:0] prog [NMEM];
  logic [31:0] rec [MAXREC];
  int          rec_n = 0;
  int          rdy_mode = 1;
  int          idle_mode = 1;
  int          tests = 0;
  int          fails = 0;

  logic [31:0] exp_w [64];
  int          exp_n;
  bit          exp_halt, exp_err;

  always #2 clk = ~clk;

  seqflow_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .cond_i(cond), .idle_i(idle),
    .disp_valid_o(disp_valid), .disp_ready_i(disp_ready), .disp_data_o(disp_data),
    .halted_o(halted), .error_o(error)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= prog[mem_addr];

  always @(negedge clk) begin
    disp_ready = (rdy_mode == 2) ? ($urandom % 4 != 0) : (rdy_mode == 1);
    idle       = (idle_mode == 2) ? ($urandom % 2 == 0) : (idle_mode == 1);
    if (rst_n && disp_valid && disp_ready && rec_n < MAXREC) begin
      rec[rec_n] = disp_data;
      rec_n++;
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(logic [3:0] op, logic [1:0] md, logic [1:0] cm,
                                     logic [6:0] imm, logic [7:0] tg);
    return {op, 1'b0, md, cm, imm, 8'h00, tg};
  endfunction

  function automatic logic [31:0] wave(logic [3:0] op, logic [27:0] pay);
    return {op, pay};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < NMEM; i++) prog[i] = mk(4'd7, 2'd0, 2'd0, 7'd0, 8'd0);
  endtask

  // Interpreter built from R2..R12
  task automatic model_run(input logic [1:0] c);
    logic [7:0] pc, tg, ret [8];
    bit arm, sarm [8], ok;
    logic [6:0] cnt, scnt [8];
    int sp;
    logic [31:0] w;
    pc = 0; sp = 0; arm = 0; cnt = 0;
    exp_n = 0; exp_halt = 0; exp_err = 0;
    for (int step = 0; step < 300; step++) begin
      if (exp_halt || exp_n >= 64) break;
      w  = prog[pc];
      ok = (w[26:25] == 2'd0) || (w[26:25] == 2'd2) ||
           (w[26:25] == 2'd1 && w[24:23] == c);
      tg = (w[26:25] == 2'd2) ? w[7:0] + {6'd0, c} : w[7:0];
      case (w[31:28])
        4'd0, 4'd1: begin exp_w[exp_n] = w; exp_n++; pc++; end
        4'd2: pc = ok ? tg : pc + 8'd1;
        4'd3: if (!ok) pc++;
              else if (sp == 8) begin exp_err = 1; exp_halt = 1; end
              else begin
                ret[sp] = pc + 8'd1; sarm[sp] = arm; scnt[sp] = cnt; sp++;
                arm = 0; cnt = 0; pc = tg;
              end
        4'd4: if (!ok) pc++;
              else if (sp == 0) begin exp_err = 1; exp_halt = 1; end
              else begin sp--; pc = ret[sp]; arm = sarm[sp]; cnt = scnt[sp]; end
        4'd5: if (!ok) begin arm = 0; pc++; end
              else if (!arm) begin
                if (w[22:16] != 0) begin arm = 1; cnt = w[22:16] - 7'd1; pc = tg; end
                else pc++;
              end else if (cnt != 0) begin cnt--; pc = tg; end
              else begin arm = 0; pc++; end
        4'd6: pc++;
        default: exp_halt = 1;
      endcase
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rec_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_prog(input string tag, input string req, input logic [1:0] c);
    bit done = 0;
    int first_bad = -1;
    cond = c;
    model_run(c);
    do_reset();
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(posedge clk); #1;
      if (exp_halt ? halted : (rec_n >= exp_n)) begin done = 1; break; end
    end
    for (int i = 0; i < exp_n && i < rec_n; i++)
      if (first_bad < 0 && rec[i] !== exp_w[i]) first_bad = i;
    if (!done || (exp_halt && rec_n != exp_n))
      chk(0, req, {tag, " dispatch count"}, rec_n, exp_n);
    else if (first_bad >= 0)
      chk(0, req, {tag, " dispatch word"}, rec[first_bad], exp_w[first_bad]);
    else
      chk(1, req, {tag, " dispatch"}, 0, 0);
    if (exp_halt) chk(error === exp_err, req, {tag, " error state"}, error, exp_err);
  endtask

  task automatic wait_halt(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(posedge clk); #1;
      if (halted) break;
    end
  endtask

  initial begin
    void'($urandom(32'h51c0_ffee));
    clear_prog();
    rst_n = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(halted == 0 && error == 0 && disp_valid == 0 && mem_addr == 0, "R1", "reset outputs",
        {halted, error, disp_valid, mem_addr}, 0);

    // R3 R4: stall holds, write flag passes through (R2)
    clear_prog();
    prog[0] = wave(4'd0, 28'h8AB_CDEF);
    prog[1] = wave(4'd1, 28'h012_3456);
    rdy_mode = 0;
    do_reset();
    repeat (10) @(posedge clk);
    #1;
    chk(disp_valid == 1 && disp_data == prog[0] && mem_addr == 0, "R4", "stalled word",
        disp_data, prog[0]);
    rdy_mode = 1;
    wait_halt(50);
    chk(rec_n == 2 && rec[0] == prog[0] && rec[1] == prog[1], "R3", "passthrough", rec[0], prog[0]);
    chk(halted == 1 && error == 0, "R12", "halt after markers", {halted, error}, 2'b10);
    chk(mem_rd == 0 && disp_valid == 0, "R12", "quiet when halted", {mem_rd, disp_valid}, 0);

    // R11: SYNC waits on idle
    clear_prog();
    prog[0] = mk(4'd6, 2'd0, 2'd0, 7'd0, 8'd0);
    prog[1] = wave(4'd0, 28'h000_0777);
    idle_mode = 0;
    do_reset();
    repeat (20) @(posedge clk);
    #1;
    chk(rec_n == 0 && mem_addr == 0 && !halted, "R11", "sync blocked", rec_n, 0);
    idle_mode = 1;
    wait_halt(50);
    chk(rec_n == 1 && rec[0] == prog[1], "R11", "sync released", rec_n, 1);

    // R2: undefined opcode halts without error
    clear_prog();
    prog[0] = wave(4'd0, 28'h000_0001);
    prog[1] = mk(4'd12, 2'd0, 2'd0, 7'd0, 8'd0);
    prog[2] = wave(4'd0, 28'h000_0002);
    run_prog("undef_op", "R2", 2'd0);
    chk(rec_n == 1 && error == 0 && halted, "R2", "undefined opcode", rec_n, 1);

    // R5 R7: goto conditions
    clear_prog();
    prog[0] = mk(4'd2, 2'd1, 2'd2, 7'd0, 8'd10);
    prog[1] = wave(4'd0, 28'h000_0011);
    prog[2] = mk(4'd2, 2'd3, 2'd0, 7'd0, 8'd10);
    prog[3] = wave(4'd1, 28'h000_0033);
    prog[10] = wave(4'd0, 28'h000_00AA);
    run_prog("goto_eq_hit", "R5", 2'd2);
    chk(rec[0] == prog[10], "R7", "equal taken", rec[0], prog[10]);
    run_prog("goto_eq_miss", "R7", 2'd1);
    chk(rec_n == 2 && rec[1] == prog[3], "R7", "never mode falls through", rec[1], prog[3]);

    // R6: multiway for each selector value
    clear_prog();
    prog[0] = mk(4'd2, 2'd2, 2'd0, 7'd0, 8'd20);
    for (int k = 0; k < 4; k++) prog[20 + k] = wave(4'd1, 28'(32'hA0 + k));
    for (int c = 0; c < 4; c++) begin
      run_prog($sformatf("multiway_%0d", c), "R6", 2'(c));
      chk(rec[0] == prog[20 + c] && rec_n == 4 - c, "R6", "multiway target", rec[0], prog[20 + c]);
    end

    // R10: loop counts and nesting through calls
    clear_prog();
    prog[0] = wave(4'd0, 28'h000_0B0B);
    prog[1] = mk(4'd5, 2'd0, 2'd0, 7'd2, 8'd0);
    run_prog("loop3", "R10", 2'd0);
    chk(rec_n == 3, "R10", "loop N=2 count", rec_n, 3);
    prog[1] = mk(4'd5, 2'd0, 2'd0, 7'd0, 8'd0);
    run_prog("loop1", "R10", 2'd0);
    chk(rec_n == 1, "R10", "loop N=0 count", rec_n, 1);
    clear_prog();
    prog[0]  = mk(4'd3, 2'd0, 2'd0, 7'd0, 8'd10);
    prog[1]  = mk(4'd5, 2'd0, 2'd0, 7'd1, 8'd0);
    prog[10] = wave(4'd0, 28'h000_0C0C);
    prog[11] = mk(4'd5, 2'd0, 2'd0, 7'd2, 8'd10);
    prog[12] = mk(4'd4, 2'd0, 2'd0, 7'd0, 8'd0);
    run_prog("loop_nested", "R8", 2'd0);
    chk(rec_n == 6 && error == 0, "R10", "per-level loop state", rec_n, 6);

    // R9: overflow, underflow, and conditional call on full stack
    clear_prog();
    prog[0] = mk(4'd3, 2'd0, 2'd0, 7'd0, 8'd0);
    run_prog("overflow", "R9", 2'd0);
    chk(error == 1 && halted == 1, "R9", "overflow error", error, 1);
    clear_prog();
    prog[0] = mk(4'd4, 2'd0, 2'd0, 7'd0, 8'd0);
    run_prog("underflow", "R9", 2'd0);
    chk(error == 1 && halted == 1, "R9", "underflow error", error, 1);
    clear_prog();
    for (int i = 0; i < 8; i++) prog[i] = mk(4'd3, 2'd0, 2'd0, 7'd0, 8'(i + 1));
    prog[8]  = mk(4'd3, 2'd1, 2'd3, 7'd0, 8'd0);
    prog[9]  = wave(4'd0, 28'h000_0D0D);
    prog[10] = mk(4'd4, 2'd1, 2'd3, 7'd0, 8'd0);
    prog[11] = mk(4'd4, 2'd0, 2'd0, 7'd0, 8'd0);
    prog[1]  = mk(4'd3, 2'd0, 2'd0, 7'd0, 8'd2);
    run_prog("full_cond_miss", "R9", 2'd0);
    chk(error == 0 && rec_n >= 1 && rec[0] == prog[9], "R9", "untaken call at full depth",
        error, 0);
    run_prog("full_cond_hit", "R9", 2'd3);
    chk(error == 1 && rec_n == 0, "R8", "taken call at full depth", error, 1);

    // Random programs under backpressure
    rdy_mode = 2;
    idle_mode = 2;
    for (int r = 0; r < 20; r++) begin
      clear_prog();
      for (int i = 0; i < 32; i++) begin
        int sel = $urandom % 100;
        logic [1:0] md = 2'($urandom % 4);
        logic [1:0] cm = 2'($urandom % 4);
        logic [7:0] tg = 8'($urandom % 32);
        if (sel < 30)      prog[i] = wave(4'd0, 28'($urandom));
        else if (sel < 40) prog[i] = wave(4'd1, 28'($urandom));
        else if (sel < 50) prog[i] = mk(4'd2, md, cm, 7'd0, tg);
        else if (sel < 62) prog[i] = mk(4'd3, md, cm, 7'd0, tg);
        else if (sel < 72) prog[i] = mk(4'd4, md, cm, 7'd0, tg);
        else if (sel < 85) prog[i] = mk(4'd5, md, cm, 7'($urandom % 4), tg);
        else if (sel < 92) prog[i] = mk(4'd6, 2'd0, 2'd0, 7'd0, 8'd0);
        else               prog[i] = mk(4'd7, 2'd0, 2'd0, 7'd0, 8'd0);
      end
      run_prog($sformatf("random_%0d", r), "R8", 2'($urandom % 4));
    end

    summary();
    $finish;
  end
endmodule